// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Formatter

This block builds the timeslot-zero byte of a 2.048 Mbit/s PCM 30 frame on the transmit side. It covers each of the 16 frames of a CRC-4 multiframe. A frame-start strobe advances an internal frame index. The index selects one of two byte types. Even frames get the alignment byte: a fixed seven-bit pattern under a leading bit. Odd frames get the non-alignment byte: a marker bit, the remote alarm bit and five national bits.

The leading bit carries different data depending on the frame:

- In even frames it carries one of the four CRC bits of the current sub-multiframe.
- In the early odd frames it carries the multiframe alignment pattern.
- In the last two odd frames it carries the two E bits.

The CRC bits come from outside the block, as do the E bits, the alarm bit and the national bits. The output byte feeds a serialiser that is not part of this block.

An active-low transmit-AIS pin overrides the formatter and drives all ones. The override is combinational, so it holds from power-up and through reset with no configuration. Raising the pin restores normal bytes.

Top module: `e1_ts0_formatter`

## Requirements
- R1: After reset the frame index is 0 and the multiframe-start output is 1.
- R2: Each cycle with the frame strobe high advances the frame index by one, wrapping from 15 to 0. In any other cycle the index holds.
- R3: The multiframe-start output is 1 exactly when the frame index is 0.
- R4: With AIS inactive and an even frame index, bits [6:0] of the output byte equal 7'b0011011. Byte bit 7 is transmitted first and bit 0 last.
- R5: With AIS inactive and an even frame index, bit 7 equals crc_in[idx[2:1]]. Here crc_in[0] is C1 and crc_in[3] is C4, so frames 0/8 carry C1, 2/10 carry C2, 4/12 carry C3 and 6/14 carry C4.
- R6: With AIS inactive and an odd frame index, bit 6 is 1, bit 5 equals remote_alarm and bits [4:0] equal nat_in. nat_in[4] is Sa4 and nat_in[0] is Sa8.
- R7: With AIS inactive, bit 7 in frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R8: With AIS inactive, bit 7 in frame 13 equals e_in[0] (E1), and in frame 15 it equals e_in[1] (E2).
- R9: While ais_n is 0 the output byte is 8'hFF, including during reset. When ais_n returns to 1, formatting resumes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | Advance to the next frame |
| crc_in | input | 4 | C1..C4 of the current sub-multiframe, C1 in bit 0 |
| e_in | input | 2 | E1 in bit 0, E2 in bit 1 |
| remote_alarm | input | 1 | Remote alarm bit for odd frames |
| nat_in | input | 5 | Sa4 (bit 4) to Sa8 (bit 0) |
| ais_n | input | 1 | Active-low transmit AIS, forces all ones |
| ts0_byte | output | 8 | Timeslot-zero byte, bit 7 sent first |
| frame_idx | output | 4 | Current frame index within the multiframe |
| mf_start | output | 1 | High while the index is 0 |

## Verification
A wrong frame index shows up at frame_idx in the first cycle after a strobe edge. It also shows in the byte type: a seven-bit pattern appears where a marker and alarm should be, or the reverse. A mis-selected leading bit shows in the same cycle as a wrong C, alignment or E bit at bit 7. The model drives random payload on every cycle, so a swapped or stuck source is exposed. An AIS fault shows as any zero bit while the pin is low, and that includes the reset cycles.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int MF_LEN = 16;
  localparam int IDX_W  = $clog2(MF_LEN);
  localparam logic [6:0] ALIGN_WORD = 7'b0011011;

  // multiframe alignment bit of odd frame number k = idx>>1, k in 0..5
  function automatic logic mfa_bit(input logic [2:0] k);
    case (k)
      3'd2, 3'd4, 3'd5: mfa_bit = 1'b1;
      default:          mfa_bit = 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] align_byte(input logic lead);
    align_byte = {lead, ALIGN_WORD};
  endfunction

  function automatic logic [7:0] nonalign_byte(input logic lead, input logic alarm,
                                               input logic [4:0] nat);
    nonalign_byte = {lead, 1'b1, alarm, nat};
  endfunction
endpackage

// File: rtl/e1_frame_counter.sv
module e1_frame_counter #(
  parameter int LEN = e1_ts0_pkg::MF_LEN,
  localparam int W = $clog2(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] idx
);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + W'(1);
  end
endmodule

// File: rtl/e1_lead_select.sv
module e1_lead_select (
  input  logic [3:0] idx,
  input  logic [3:0] crc_in,
  input  logic [1:0] e_in,
  output logic       lead
);
  import e1_ts0_pkg::*;

  always_comb begin
    if (!idx[0])               lead = crc_in[idx[2:1]];
    else if (idx[3:1] == 3'd6) lead = e_in[0];
    else if (idx[3:1] == 3'd7) lead = e_in[1];
    else                       lead = mfa_bit(idx[3:1]);
  end
endmodule

// File: rtl/e1_ts0_formatter.sv
module e1_ts0_formatter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_strobe,
  input  logic [3:0] crc_in,
  input  logic [1:0] e_in,
  input  logic       remote_alarm,
  input  logic [4:0] nat_in,
  input  logic       ais_n,
  output logic [7:0] ts0_byte,
  output logic [3:0] frame_idx,
  output logic       mf_start
);
  import e1_ts0_pkg::*;

  logic       lead_bit;
  logic       is_align;
  logic [7:0] fmt_byte;

  e1_frame_counter #(.LEN(MF_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(frame_strobe), .idx(frame_idx)
  );

  e1_lead_select u_lead (
    .idx(frame_idx), .crc_in(crc_in), .e_in(e_in), .lead(lead_bit)
  );

  assign is_align = ~frame_idx[0];
  assign fmt_byte = is_align ? align_byte(lead_bit)
                             : nonalign_byte(lead_bit, remote_alarm, nat_in);
  assign ts0_byte = ais_n ? fmt_byte : 8'hFF;
  assign mf_start = (frame_idx == '0);
endmodule

// File: rtl/e1_ts0_checker.sv
module e1_ts0_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_strobe,
  input logic       ais_n,
  input logic       remote_alarm,
  input logic [3:0] crc_in,
  input logic [4:0] nat_in,
  input logic [3:0] frame_idx,
  input logic       mf_start,
  input logic       lead_bit,
  input logic [7:0] ts0_byte
);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> frame_idx == 4'($past(frame_idx) + 4'd1));
  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(frame_idx));
  // R9
  ais_ones_chk: assert property (@(posedge clk) !ais_n |-> ts0_byte == 8'hFF);
  // R4
  align_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_n && !frame_idx[0]) |-> ts0_byte[6:0] == 7'b0011011);
  // R6
  nonalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_n && frame_idx[0]) |-> ts0_byte[6:0] == {1'b1, remote_alarm, nat_in});
  // R5 R3
  mf_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ais_n && mf_start) |-> (ts0_byte[7] == crc_in[0] && lead_bit == crc_in[0]));
endmodule

bind e1_ts0_formatter e1_ts0_checker chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .ais_n(ais_n),
  .remote_alarm(remote_alarm), .crc_in(crc_in), .nat_in(nat_in),
  .frame_idx(frame_idx), .mf_start(mf_start), .lead_bit(lead_bit),
  .ts0_byte(ts0_byte)
);

// File: tb/tb_e1_ts0_formatter.sv
module tb_e1_ts0_formatter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strobe = 1'b0;
  logic [3:0] crc_in = '0;
  logic [1:0] e_in = '0;
  logic       remote_alarm = 1'b0;
  logic [4:0] nat_in = '0;
  logic       ais_n = 1'b0;
  logic [7:0] ts0_byte;
  logic [3:0] frame_idx;
  logic       mf_start;

  int checks = 0;
  int errors = 0;
  int midx = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_ts0_formatter dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit 7 of odd frames 1..11 in order
  function automatic bit odd_lead(input int i);
    bit [5:0] pat = 6'b001011;
    if (i == 13) return e_in[0];
    if (i == 15) return e_in[1];
    return pat[5 - i/2];
  endfunction

  task automatic check_frame();
    check("R2", frame_idx, midx);
    check("R3", mf_start, midx == 0);
    if (!ais_n) check("R9", ts0_byte, 8'hFF);
    else if (midx % 2 == 0) begin
      check("R4", ts0_byte[6:0], 7'h1B);
      check("R5", ts0_byte[7], crc_in[(midx % 8) / 2]);
    end else begin
      check("R6", ts0_byte[6:0], {1'b1, remote_alarm, nat_in});
      if (midx >= 13) check("R8", ts0_byte[7], odd_lead(midx));
      else            check("R7", ts0_byte[7], odd_lead(midx));
    end
  endtask

  task automatic step(input bit strobe, input bit ais);
    @(negedge clk);
    frame_strobe = strobe; ais_n = ais;
    crc_in = 4'($urandom); e_in = 2'($urandom);
    remote_alarm = 1'($urandom); nat_in = 5'($urandom);
    #1 check_frame();
    @(posedge clk);
    if (strobe) midx = (midx + 1) % 16;
  endtask

  initial begin
    void'($urandom(32'h5eed_e101));
    // AIS during reset
    repeat (2) @(negedge clk);
    #1 check("R9", ts0_byte, 8'hFF);
    ais_n = 1'b1;
    #1 check("R1", frame_idx, 0);
    check("R1", mf_start, 1);
    @(negedge clk) rst_n = 1'b1;
    // directed: walk two multiframes with AIS off
    for (int i = 0; i < 33; i++) step(1, 1);
    // hold without strobe
    for (int i = 0; i < 4; i++) step(0, 1);
    // AIS toggling mid-multiframe
    for (int i = 0; i < 6; i++) step(1, 0);
    step(0, 1);
    // random mix
    for (int i = 0; i < 2000; i++) step(1'($urandom), ($urandom % 8) != 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule